// File: doc/BRIEF.md
# Thermal Threshold Throttle Controller

This block watches a 7-bit die temperature sample, given in whole degrees Celsius, and turns it into a throttle request and a shutdown request. Software sets the limits through a 64-bit control word. The control word holds a low warning limit and a high warning limit, each with its own enable bit. It also holds a trip limit and a policy bit. The policy bit picks how hard the block throttles once only the low limit has been reached. Reaching the high limit always asks for full throttling. Reaching the trip limit raises a shutdown request.

A capability input tells the block that the device cannot throttle itself. When that input is 1, the throttle output stays at none, and the block still reports temperature, status and trip. Software sees a second register, which is read-only and holds the current registered sample. Clock gating and power-down sequencing sit outside this block and act on its two outputs.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: While and after reset, with no write yet, the throttle output is none (code 0) and the shutdown request is 0. The control word reads 0x7F00_0000: both enables 0, policy 0, trip limit equal to the TRIP_RESET parameter (127) in bits 30:24.
- R2: A limit counts as reached when its enable bit is 1 and the sample is greater than or equal to the limit. If only the low limit (bits 6:0, enable bit 7) is reached and policy bit 44 is 0, the throttle output is 90% (code 2) and status bit 32 reads 1. One degree below the limit, the output is none.
- R3: If only the low limit is reached and policy bit 44 is 1, the throttle output is 50% (code 1).
- R4: If the high limit (bits 14:8, enable bit 15) is reached, the throttle output is 100% (code 3) whatever the policy, and status bit 33 reads 1. When both limits are reached, the high limit wins.
- R5: A limit whose enable bit is 0 is never reached. It sets no status bit and causes no throttling.
- R6: The shutdown request is 1 exactly when the sample is greater than or equal to the trip limit (bits 30:24). The trip limit has no enable bit.
- R7: While the capability input no_throttle_i is 1, the throttle output is none. Status bits and the shutdown request still follow the comparisons.
- R8: A write to the control word (address 0) updates only the two limits, their enables, the trip limit and the policy bit. The status bits 32 and 33 and all reserved bits ignore the written value: status follows the current comparison, and reserved bits read 0. Status is not sticky.
- R9: Address 1 reads the registered sample in bits 6:0, with all other bits 0.
- R10: A sample present before clock edge k is registered at edge k. The throttle output, shutdown request and status bits that depend on it change at edge k+1, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_i | input | 7 | Die temperature sample, whole degrees Celsius |
| no_throttle_i | input | 1 | 1 = the device cannot throttle, so the throttle output is forced to none |
| reg_wr_i | input | 1 | Write strobe for the control word |
| reg_addr_i | input | 1 | Register select: 0 = control/status word, 1 = sensor word |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Read data for the selected register |
| throttle_o | output | 2 | Throttle level: 0 none, 1 50%, 2 90%, 3 100% |
| shutdown_o | output | 1 | Shutdown request |

## Verification
A wrong limit, enable or policy register shows at the throttle output one edge after the next sample is evaluated. It also shows at once on a read of the control word. A status bit that was latched by mistake, or a write that leaked into a status bit, shows on the next read at address 0 after a temperature that no longer reaches the limit. A wrong priority between the limits, or a capability input that is ignored, changes the throttle code two edges after the sample is applied. The bench samples that code exactly there and also one edge earlier.

// File: rtl/tt_pkg.sv
package tt_pkg;
    localparam int TEMP_W = 7;
    localparam int WORD_W = 64;

    // Field positions in the control/status word
    localparam int LO_LSB     = 0;
    localparam int LO_EN_BIT  = 7;
    localparam int HI_LSB     = 8;
    localparam int HI_EN_BIT  = 15;
    localparam int TRIP_LSB   = 24;
    localparam int ST_LO_BIT  = 32;
    localparam int ST_HI_BIT  = 33;
    localparam int POLICY_BIT = 44;

    typedef enum logic [1:0] {
        THR_NONE   = 2'd0,
        THR_HALF   = 2'd1,
        THR_NINETY = 2'd2,
        THR_FULL   = 2'd3
    } thr_level_e;

    typedef struct packed {
        logic              policy_half;
        logic [TEMP_W-1:0] trip;
        logic              en_hi;
        logic [TEMP_W-1:0] lim_hi;
        logic              en_lo;
        logic [TEMP_W-1:0] lim_lo;
    } cfg_t;

    typedef struct packed {
        logic hit_hi;
        logic hit_lo;
    } stat_t;

    function automatic cfg_t unpack_cfg(input logic [WORD_W-1:0] w);
        cfg_t c;
        c.lim_lo      = w[LO_LSB   +: TEMP_W];
        c.en_lo       = w[LO_EN_BIT];
        c.lim_hi      = w[HI_LSB   +: TEMP_W];
        c.en_hi       = w[HI_EN_BIT];
        c.trip        = w[TRIP_LSB +: TEMP_W];
        c.policy_half = w[POLICY_BIT];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_ctrl(input cfg_t c, input stat_t s);
        logic [WORD_W-1:0] w;
        w = '0;
        w[LO_LSB   +: TEMP_W] = c.lim_lo;
        w[LO_EN_BIT]          = c.en_lo;
        w[HI_LSB   +: TEMP_W] = c.lim_hi;
        w[HI_EN_BIT]          = c.en_hi;
        w[TRIP_LSB +: TEMP_W] = c.trip;
        w[ST_LO_BIT]          = s.hit_lo;
        w[ST_HI_BIT]          = s.hit_hi;
        w[POLICY_BIT]         = c.policy_half;
        return w;
    endfunction
endpackage

// File: rtl/tt_cfg_regs.sv
module tt_cfg_regs
    import tt_pkg::*;
#(
    parameter logic [TEMP_W-1:0] TRIP_RESET = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic              addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output cfg_t              cfg_o
);
    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= '0;
            cfg_q.trip <= TRIP_RESET;
        end else if (wr_i && !addr_i) begin
            cfg_q <= unpack_cfg(wdata_i);
        end
    end

    assign cfg_o = cfg_q;

    // R8: configuration moves only on a write strobe
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_i) |-> $stable(cfg_q));
endmodule

// File: rtl/tt_eval.sv
module tt_eval
    import tt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic              no_thr_i,
    input  cfg_t              cfg_i,
    output logic [TEMP_W-1:0] temp_o,
    output stat_t             stat_o,
    output thr_level_e        level_o,
    output logic              shut_o
);
    logic [TEMP_W-1:0] temp_q;
    logic              no_thr_q;
    stat_t             stat_d, stat_q;
    thr_level_e        level_d, level_q;
    logic              shut_d, shut_q;

    // Stage 1: register the sample and the capability
    always_ff @(posedge clk) begin
        if (rst) begin
            temp_q   <= '0;
            no_thr_q <= 1'b0;
        end else begin
            temp_q   <= temp_i;
            no_thr_q <= no_thr_i;
        end
    end

    // Stage 2: compare and pick a level
    always_comb begin
        stat_d.hit_lo = cfg_i.en_lo && (temp_q >= cfg_i.lim_lo);
        stat_d.hit_hi = cfg_i.en_hi && (temp_q >= cfg_i.lim_hi);
        shut_d        = (temp_q >= cfg_i.trip);
        if (no_thr_q)           level_d = THR_NONE;
        else if (stat_d.hit_hi) level_d = THR_FULL;
        else if (stat_d.hit_lo) level_d = cfg_i.policy_half ? THR_HALF : THR_NINETY;
        else                    level_d = THR_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q  <= '0;
            level_q <= THR_NONE;
            shut_q  <= 1'b0;
        end else begin
            stat_q  <= stat_d;
            level_q <= level_d;
            shut_q  <= shut_d;
        end
    end

    assign temp_o  = temp_q;
    assign stat_o  = stat_q;
    assign level_o = level_q;
    assign shut_o  = shut_q;

    // R7: no throttling when the device lacks the capability
    p_cap_none_r7: assert property (@(posedge clk) disable iff (rst)
        $past(no_thr_q) |-> level_q == THR_NONE);
    // R4: high limit status always means full throttle when capable
    p_hi_full_r4: assert property (@(posedge clk) disable iff (rst)
        (stat_q.hit_hi && !$past(no_thr_q)) |-> level_q == THR_FULL);
    // R5: any throttling needs a reached (enabled) limit
    p_level_needs_hit_r5: assert property (@(posedge clk) disable iff (rst)
        (level_q != THR_NONE) |-> (stat_q.hit_lo || stat_q.hit_hi));
    // R3: partial throttle codes only without the high limit
    p_partial_lo_only_r3: assert property (@(posedge clk) disable iff (rst)
        (level_q == THR_HALF || level_q == THR_NINETY) |-> (stat_q.hit_lo && !stat_q.hit_hi));
endmodule

// File: rtl/tt_readout.sv
module tt_readout
    import tt_pkg::*;
(
    input  logic              addr_i,
    input  cfg_t              cfg_i,
    input  stat_t             stat_i,
    input  logic [TEMP_W-1:0] temp_i,
    output logic [WORD_W-1:0] rdata_o
);
    always_comb begin
        if (addr_i) rdata_o = {{(WORD_W-TEMP_W){1'b0}}, temp_i};
        else        rdata_o = pack_ctrl(cfg_i, stat_i);
    end
endmodule

// File: rtl/thermal_throttle_ctrl.sv
module thermal_throttle_ctrl
    import tt_pkg::*;
#(
    parameter logic [6:0] TRIP_RESET = 7'd127
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [6:0]  temp_i,
    input  logic        no_throttle_i,
    input  logic        reg_wr_i,
    input  logic        reg_addr_i,
    input  logic [63:0] reg_wdata_i,
    output logic [63:0] reg_rdata_o,
    output logic [1:0]  throttle_o,
    output logic        shutdown_o
);
    cfg_t              cfg;
    stat_t             stat;
    thr_level_e        level;
    logic [TEMP_W-1:0] temp_q;

    tt_cfg_regs #(.TRIP_RESET(TRIP_RESET)) u_regs (
        .clk(clk), .rst(rst), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .cfg_o(cfg)
    );

    tt_eval u_eval (
        .clk(clk), .rst(rst), .temp_i(temp_i), .no_thr_i(no_throttle_i),
        .cfg_i(cfg), .temp_o(temp_q), .stat_o(stat), .level_o(level),
        .shut_o(shutdown_o)
    );

    tt_readout u_rd (
        .addr_i(reg_addr_i), .cfg_i(cfg), .stat_i(stat), .temp_i(temp_q),
        .rdata_o(reg_rdata_o)
    );

    assign throttle_o = level;

    // R1: outputs idle in the cycle after reset
    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> (throttle_o == 2'd0 && !shutdown_o));
endmodule

// File: tb/thermal_throttle_ctrl_tb.sv
`timescale 1ns/1ps
module thermal_throttle_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [6:0]  temp;
    logic        nothr;
    logic        wr;
    logic        addr;
    logic [63:0] wdata;
    logic [63:0] rdata;
    logic [1:0]  thr;
    logic        sd;

    always #2.5 clk = ~clk;

    thermal_throttle_ctrl u_dut (
        .clk(clk), .rst(rst), .temp_i(temp), .no_throttle_i(nothr),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .throttle_o(thr), .shutdown_o(sd)
    );

    int tests = 0;
    int fails = 0;
    int cycle = 0;
    bit done  = 0;
    always @(posedge clk) cycle <= cycle + 1;

    // bench-side model of the configuration
    int m_lo, m_hi, m_trip;
    bit m_en_lo, m_en_hi, m_pol;

    typedef struct {
        int         due;
        logic [1:0] lvl;
        logic       sd;
        string      tag;
    } exp_t;
    exp_t sb[$];

    function automatic logic [1:0] model_lvl(int t, bit cap);
        bit lo, hi;
        lo = m_en_lo && (t >= m_lo);
        hi = m_en_hi && (t >= m_hi);
        if (cap) return 2'd0;
        if (hi) return 2'd3;
        if (lo) return m_pol ? 2'd1 : 2'd2;
        return 2'd0;
    endfunction

    function automatic logic [63:0] model_ctrl(int t);
        logic [63:0] w;
        w = '0;
        w[6:0]   = m_lo[6:0];
        w[7]     = m_en_lo;
        w[14:8]  = m_hi[6:0];
        w[15]    = m_en_hi;
        w[30:24] = m_trip[6:0];
        w[32]    = m_en_lo && (t >= m_lo);
        w[33]    = m_en_hi && (t >= m_hi);
        w[44]    = m_pol;
        return w;
    endfunction

    // monitor: compare scoreboard entries when due
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due == cycle) begin
            exp_t e;
            e = sb.pop_front();
            tests++;
            if (thr !== e.lvl || sd !== e.sd) begin
                fails++;
                $display("FAIL %s: throttle=%0d shutdown=%0d expected throttle=%0d shutdown=%0d",
                         e.tag, thr, sd, e.lvl, e.sd);
            end
        end
    end

    task automatic apply(input int t, input bit cap, input string tag);
        exp_t e;
        @(negedge clk);
        temp  = t[6:0];
        nothr = cap;
        e.due = cycle + 2;
        e.lvl = model_lvl(t, cap);
        e.sd  = (t >= m_trip);
        e.tag = tag;
        sb.push_back(e);
        repeat (2) @(negedge clk);
        #1;
    endtask

    task automatic write_ctrl(input logic [63:0] d);
        @(negedge clk);
        wr = 1'b1; addr = 1'b0; wdata = d;
        @(negedge clk);
        wr = 1'b0;
        m_lo = int'(d[6:0]);    m_en_lo = d[7];
        m_hi = int'(d[14:8]);   m_en_hi = d[15];
        m_trip = int'(d[30:24]); m_pol = d[44];
    endtask

    task automatic read_check(input logic a, input logic [63:0] exp, input string tag);
        addr = a;
        #1;
        tests++;
        if (rdata !== exp) begin
            fails++;
            $display("FAIL %s: rdata=0x%016h expected 0x%016h", tag, rdata, exp);
        end
    endtask

    task automatic check_bit(input logic act, input logic exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; temp = '0; nothr = 1'b0; wr = 1'b0; addr = 1'b0; wdata = '0;
        m_lo = 0; m_hi = 0; m_trip = 127; m_en_lo = 0; m_en_hi = 0; m_pol = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check_bit(thr == 2'd0, 1'b1, "R1 throttle none in reset");
        check_bit(sd, 1'b0, "R1 shutdown low in reset");
        read_check(1'b0, 64'h0000_0000_7F00_0000, "R1 control word reset value");
        rst = 1'b0;
        apply(50, 0, "R1 idle after reset");

        // configure: lo=60 en, hi=80 en, trip=100, policy 0
        write_ctrl(64'h0000_0000_6400_D0BC);
        read_check(1'b0, model_ctrl(50), "R8 control readback");

        apply(59, 0, "R2 one below low limit");
        apply(60, 0, "R2 low limit reached gives 90");
        read_check(1'b0, model_ctrl(60), "R2 status bit 32 set");

        // R10 latency: change to hi-reaching sample and look one edge early
        @(negedge clk);
        temp = 7'd80;
        @(negedge clk);
        check_bit(thr == 2'd2, 1'b1, "R10 output unchanged one edge after sample");
        @(negedge clk);
        check_bit(thr == 2'd3, 1'b1, "R10 output changes on second edge");

        write_ctrl(64'h0000_1000_6400_D0BC);
        apply(70, 0, "R3 policy 1 gives 50");
        apply(80, 0, "R4 high limit gives full over policy");
        read_check(1'b0, model_ctrl(80), "R4 both status bits set");

        write_ctrl(64'h0000_1000_6400_50BC);
        apply(85, 0, "R5 disabled high limit ignored");
        read_check(1'b0, model_ctrl(85), "R5 no status for disabled limit");
        write_ctrl(64'h0000_1000_6400_503C);
        apply(85, 0, "R5 both limits disabled");

        write_ctrl(64'h0000_0000_6400_D0BC);
        apply(99, 0, "R6 one below trip");
        apply(100, 0, "R6 trip reached");
        apply(127, 0, "R6 max sample trips");

        apply(90, 1, "R7 capability off forces none");
        read_check(1'b0, model_ctrl(90), "R7 status still follows");
        apply(100, 1, "R7 trip still works without throttle");
        apply(90, 0, "R7 capability restored");

        apply(50, 0, "R8 cool sample before write");
        write_ctrl(64'hFFFF_FFFF_FFFF_FFFF);
        read_check(1'b0, 64'h0000_1000_7F00_FFFF, "R8 status and reserved ignore writes");
        write_ctrl(64'h0000_0000_6400_D0BC);
        apply(85, 0, "R8 status hot");
        apply(40, 0, "R8 status cooled");
        read_check(1'b0, model_ctrl(40), "R8 status not sticky");

        apply(42, 0, "R9 sensor sample");
        read_check(1'b1, 64'd42, "R9 sensor register");
        apply(127, 0, "R9 sensor max");
        read_check(1'b1, 64'd127, "R9 sensor register max");

        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule